// File: doc/BRIEF.md
# Two-Phase Latch Toggle Counter

This block holds two small counters made from one repeated storage element: a toggle cell whose bit lives in a pair of transparent latches. The first latch is open while clock phase `phi1` is high and takes the cell's next value. The second latch is open while phase `phi2` is high and passes that value to the output. The two phases never overlap, so a bit cannot race through both latches in one phase. Inside each cell, an active-low clear overrides the active-high toggle enable.

Several cells are chained to form a binary counter that divides by eight. A bit toggles when the count enable is high and every lower bit is one. Two more cells form a counter that divides by three. This counter steps 0, 1, 2 and returns to 0, because its own terminal count, gated by the enable, drives the cells' clear in the same way the external clear does. The two counters share the count enable and the clear. The two phases come straight from the block's inputs. A "phase pair" below means one `phi1` pulse followed by one `phi2` pulse, with both phases low between them.

Top module: `tcnt_top`

## Requirements
- R1: A phase pair with `clr` high leaves both `cnt8` and `cnt3` at zero, whatever value `ce` has.
- R2: A phase pair with `ce` high and `clr` low raises `cnt8` by one, modulo 8, so 7 is followed by 0.
- R3: A phase pair with `ce` high and `clr` low moves `cnt3` from 0 to 1, from 1 to 2 (binary 10) and from 2 to 0.
- R4: A phase pair with `ce` low and `clr` low leaves `cnt8` and `cnt3` unchanged. This holds when `cnt3` sits at 2 and when `cnt8` sits at 7.
- R5: A `phi1` pulse alone does not change either output. The new count appears only after the following `phi2` pulse.
- R6: Once `clr` has been applied, `cnt3` never shows the value 3 (binary 11).
- R7: When `ce` and `clr` are both high in the same phase pair, the clear wins and both counts become zero. This applies even when `cnt8` is 7 or `cnt3` is 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| phi1 | input | 1 | First clock phase; loads the first latch of every cell |
| phi2 | input | 1 | Second clock phase, never high together with phi1; loads the output latch |
| ce | input | 1 | Count enable, active high |
| clr | input | 1 | Clear, active high, takes priority over ce |
| cnt8 | output | CNT8_W | Binary count of the divide-by-eight counter |
| cnt3 | output | 2 | Count of the divide-by-three counter |

## Verification
The bench tries four kinds of input pattern.

- **Long run with `ce` held high.** This walks `cnt8` through several wraps and `cnt3` through several terminal-count clears. It shows whether carries spread correctly and whether the modulo-3 counter clears itself.
- **Hold stretches at the terminal counts.** These stretches keep `ce` low while `cnt8` is 7 and `cnt3` is 2. They show whether the self-clear wrongly ignores the enable.
- **Pseudo-random mix of `ce` and `clr`.** This includes `clr` together with `ce` at the terminal counts. It shows whether the clear really overrides the toggle.
- **Output read between `phi1` and `phi2`.** Every phase pair reads the outputs at this point. This shows whether the second latch wrongly lets the value through early.

// File: rtl/tcnt_pkg.sv
package tcnt_pkg;

    // Width of the binary (divide-by-eight) counter
    localparam int CNT8_W = 3;
    // The modulo-3 counter needs two cells
    localparam int CNT3_W = 2;
    // Terminal count of the modulo-3 counter (binary 10)
    localparam logic [CNT3_W-1:0] CNT3_TC = 2'b10;

    // Control inputs seen by one toggle cell
    typedef struct packed {
        logic te;     // toggle enable, active high
        logic clr_n;  // clear, active low, dominant
    } cell_ctl_t;

    // Next value of a cell: clear beats toggle, toggle beats hold
    function automatic logic cell_next(cell_ctl_t ctl, logic q);
        if (!ctl.clr_n)
            return 1'b0;
        else if (ctl.te)
            return ~q;
        else
            return q;
    endfunction

endpackage

// File: rtl/tcnt_cell.sv
module tcnt_cell
    import tcnt_pkg::*;
(
    input  logic      phi1,
    input  logic      phi2,
    input  cell_ctl_t ctl,
    output logic      q
);

    // First latch: open on phi1, takes the next value
    logic stage1;

    always_latch begin
        if (phi1)
            stage1 <= cell_next(ctl, q);
    end

    // Second latch: open on phi2, drives the output
    always_latch begin
        if (phi2)
            q <= stage1;
    end

endmodule

// File: rtl/tcnt_binary.sv
module tcnt_binary
    import tcnt_pkg::*;
#(
    parameter int W = CNT8_W
) (
    input  logic         phi1,
    input  logic         phi2,
    input  logic         ce,
    input  logic         clr,
    output logic [W-1:0] q
);

    // carry[i] is high when ce is high and all bits below i are one
    logic [W-1:0] carry;
    cell_ctl_t    ctl [W];

    for (genvar i = 0; i < W; i++) begin : g_bit
        if (i == 0) begin : g_lsb
            assign carry[i] = ce;
        end else begin : g_upper
            assign carry[i] = carry[i-1] & q[i-1];
        end

        assign ctl[i].te    = carry[i];
        assign ctl[i].clr_n = ~clr;

        tcnt_cell u_cell (
            .phi1 (phi1),
            .phi2 (phi2),
            .ctl  (ctl[i]),
            .q    (q[i])
        );
    end

endmodule

// File: rtl/tcnt_mod3.sv
module tcnt_mod3
    import tcnt_pkg::*;
(
    input  logic              phi1,
    input  logic              phi2,
    input  logic              ce,
    input  logic              clr,
    output logic [CNT3_W-1:0] q
);

    // Terminal count reached while enabled: clear on this pair
    logic      at_tc;
    logic      clr_any_n;
    cell_ctl_t ctl_lo;
    cell_ctl_t ctl_hi;

    assign at_tc     = ce && (q == CNT3_TC);
    assign clr_any_n = ~(clr | at_tc);

    assign ctl_lo.te    = ce;
    assign ctl_lo.clr_n = clr_any_n;
    assign ctl_hi.te    = ce & q[0];
    assign ctl_hi.clr_n = clr_any_n;

    tcnt_cell u_lo (
        .phi1 (phi1),
        .phi2 (phi2),
        .ctl  (ctl_lo),
        .q    (q[0])
    );

    tcnt_cell u_hi (
        .phi1 (phi1),
        .phi2 (phi2),
        .ctl  (ctl_hi),
        .q    (q[1])
    );

endmodule

// File: rtl/tcnt_top.sv
module tcnt_top
    import tcnt_pkg::*;
#(
    parameter int CNT8_W_P = CNT8_W
) (
    input  logic                phi1,
    input  logic                phi2,
    input  logic                ce,
    input  logic                clr,
    output logic [CNT8_W_P-1:0] cnt8,
    output logic [1:0]          cnt3
);

    tcnt_binary #(
        .W (CNT8_W_P)
    ) u_bin (
        .phi1 (phi1),
        .phi2 (phi2),
        .ce   (ce),
        .clr  (clr),
        .q    (cnt8)
    );

    tcnt_mod3 u_mod3 (
        .phi1 (phi1),
        .phi2 (phi2),
        .ce   (ce),
        .clr  (clr),
        .q    (cnt3)
    );

endmodule

// File: rtl/tcnt_checker.sv
module tcnt_checker #(
    parameter int W = 3
) (
    input logic         phi2,
    input logic         ce,
    input logic         clr,
    input logic [W-1:0] cnt8,
    input logic [1:0]   cnt3
);

    // Becomes true at the end of the first phase pair that carried a clear
    logic armed = 1'b0;

    always_ff @(negedge phi2) begin
        if (clr)
            armed <= 1'b1;
    end

    // Sampled at each falling phi2, when the pair's result is on the outputs
    p_clear_r1: assert property (@(negedge phi2) disable iff (!armed)
        clr |-> (cnt8 == '0) && (cnt3 == 2'd0));

    p_clear_wins_r7: assert property (@(negedge phi2) disable iff (!armed)
        (clr && ce) |-> (cnt8 == '0) && (cnt3 == 2'd0));

    p_count8_r2: assert property (@(negedge phi2) disable iff (!armed)
        (ce && !clr) |-> (cnt8 == $past(cnt8) + 1'b1));

    p_count3_r3: assert property (@(negedge phi2) disable iff (!armed)
        (ce && !clr) |->
            (cnt3 == (($past(cnt3) == 2'd2) ? 2'd0 : $past(cnt3) + 2'd1)));

    p_hold_r4: assert property (@(negedge phi2) disable iff (!armed)
        (!ce && !clr) |-> ($stable(cnt8) && $stable(cnt3)));

    p_no_three_r6: assert property (@(negedge phi2) disable iff (!armed)
        cnt3 != 2'd3);

endmodule

bind tcnt_top tcnt_checker #(.W(CNT8_W_P)) u_chk (
    .phi2 (phi2),
    .ce   (ce),
    .clr  (clr),
    .cnt8 (cnt8),
    .cnt3 (cnt3)
);

// File: tb/tb_tcnt_top.sv
module tb_tcnt_top;

    localparam int CLK_PERIOD = 20;
    localparam int PW         = CLK_PERIOD / 4;   // pulse width and dead gap

    logic       phi1 = 1'b0;
    logic       phi2 = 1'b0;
    logic       ce   = 1'b0;
    logic       clr  = 1'b0;
    logic [2:0] cnt8;
    logic [1:0] cnt3;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    int exp8 = 0;
    int exp3 = 0;

    tcnt_top dut (
        .phi1 (phi1),
        .phi2 (phi2),
        .ce   (ce),
        .clr  (clr),
        .cnt8 (cnt8),
        .cnt3 (cnt3)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One phase pair; inputs change only while both phases are low
    task automatic pair(input logic c_en, input logic c_clr);
        int old8;
        int old3;
        old8 = int'(cnt8);
        old3 = int'(cnt3);
        ce  = c_en;
        clr = c_clr;
        #PW phi1 = 1'b1;
        #PW phi1 = 1'b0;
        #PW;
        check("R5 cnt8 after phi1", int'(cnt8), old8);
        check("R5 cnt3 after phi1", int'(cnt3), old3);
        phi2 = 1'b1;
        #PW phi2 = 1'b0;
        if (c_clr) begin
            exp8 = 0;
            exp3 = 0;
        end else if (c_en) begin
            exp8 = (exp8 + 1) % 8;
            exp3 = (exp3 + 1) % 3;
        end
        #1;
        if (c_clr && c_en) begin
            check("R7 cnt8", int'(cnt8), 0);
            check("R7 cnt3", int'(cnt3), 0);
        end else if (c_clr) begin
            check("R1 cnt8", int'(cnt8), 0);
            check("R1 cnt3", int'(cnt3), 0);
        end else if (c_en) begin
            check("R2 cnt8", int'(cnt8), exp8);
            check("R3 cnt3", int'(cnt3), exp3);
        end else begin
            check("R4 cnt8", int'(cnt8), exp8);
            check("R4 cnt3", int'(cnt3), exp3);
        end
        check("R6 cnt3 not 3", int'(cnt3 == 2'd3), 0);
    endtask

    initial begin
        logic [7:0] lfsr;
        // Reset state through the clear
        pair(1'b0, 1'b1);
        pair(1'b1, 1'b1);

        // Long enabled run: several wraps of both counters
        for (int i = 0; i < 30; i++) pair(1'b1, 1'b0);

        // Hold at cnt8 == 7 and cnt3 == 2 (reached after 23 steps from 0)
        pair(1'b0, 1'b1);
        for (int i = 0; i < 23; i++) pair(1'b1, 1'b0);
        check("R4 setup cnt8 at 7", int'(cnt8), 7);
        check("R4 setup cnt3 at 2", int'(cnt3), 2);
        for (int i = 0; i < 6; i++) pair(1'b0, 1'b0);

        // Clear together with enable at the terminal counts
        pair(1'b1, 1'b1);
        check("R7 cleared from terminal", int'(cnt8) + int'(cnt3), 0);

        // Pseudo-random mix of enable and clear
        lfsr = 8'hA5;
        for (int i = 0; i < 400; i++) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            pair(lfsr[0] | lfsr[1], lfsr[4:2] == 3'b000);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule